// File: doc/BRIEF.md
# Interrupt Acceptance Controller

This block decides when a small 8-bit processor core takes an interrupt. It holds a pair of interrupt-enable flip-flops, a primary enable that gates maskable requests and a saved copy. Decoded instruction strobes from the core drive them: disable, enable, return-from-non-maskable, and a load of a special register into the accumulator, which reads the saved copy out as the parity flag.

The core marks each instruction boundary with a strobe, and requests are only sampled there. A rising edge on the non-maskable input is latched until a boundary serves it. It is always taken, whatever the enables hold, and it wins over a maskable request in the same cycle. A maskable request is taken only when the primary enable is set, and never at the first boundary after an enable instruction. On acceptance the block pulses an acknowledge for one cycle. Alongside it, the block reports the kind of interrupt, the response mode, the restart or table address, and the byte captured from the data bus.

Top module: `irq_accept_ctrl`

## Requirements
- R1: Reset clears both enable flip-flops and sets response mode 0. A disable strobe clears both flip-flops at the next clock edge.
- R2: An enable strobe sets both enable flip-flops at the next clock edge.
- R3: A pending non-maskable interrupt is acknowledged at a boundary whether the primary enable is set or not, with ack_nmi=1 and rst_addr=0x0066. The primary enable is cleared and the saved copy is left unchanged.
- R4: A return-from-non-maskable strobe copies the saved enable into the primary enable.
- R5: While the load-special strobe is high, pv_valid is 1 and pv_flag equals the saved enable, in the same cycle.
- R6: nmi_in is edge triggered. A rise is held pending through cycles without a boundary. A level that stays high gives exactly one acknowledge.
- R7: When a non-maskable interrupt is pending and a maskable request is present at the same boundary, only the non-maskable one is acknowledged.
- R8: A maskable request is acknowledged only if the primary enable is 1 at the boundary. Acceptance clears both flip-flops.
- R9: At the first boundary after an enable strobe, no maskable request is acknowledged. It is taken at the boundary after that.
- R10: A mode write of 0, 1 or 2 selects that response mode. A write of value 3 is ignored and the previous mode stays in force.
- R11: In mode 0 a maskable acknowledge gives ack_mode=0, rst_addr=0, and ack_opcode equal to bus_data at the boundary.
- R12: In mode 1 a maskable acknowledge gives ack_mode=1 and rst_addr=0x0038.
- R13: In mode 2 a maskable acknowledge gives ack_mode=2 and rst_addr={vec_page, bus_data with bit 0 cleared}.
- R14: ack is high for exactly the one cycle after the clock edge that sampled the boundary, and never without a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| di_stb | input | 1 | Disable-interrupts instruction strobe |
| ei_stb | input | 1 | Enable-interrupts instruction strobe |
| retn_stb | input | 1 | Return-from-non-maskable strobe |
| ldsp_stb | input | 1 | Load special register into accumulator strobe |
| mode_wr | input | 1 | Response mode write strobe |
| mode_sel | input | 2 | Response mode value to write |
| boundary | input | 1 | Instruction boundary strobe |
| int_req | input | 1 | Maskable request, level |
| nmi_in | input | 1 | Non-maskable request, edge |
| bus_data | input | 8 | Byte supplied by the device during acknowledge |
| vec_page | input | 8 | High byte of the mode 2 table address |
| ack | output | 1 | One-cycle acknowledge |
| ack_nmi | output | 1 | Acknowledge was non-maskable |
| ack_mode | output | 2 | Response mode of the last maskable acknowledge |
| rst_addr | output | 16 | Restart or table address |
| ack_opcode | output | 8 | Byte captured on a maskable acknowledge |
| iff1 | output | 1 | Primary enable flip-flop |
| iff2 | output | 1 | Saved enable flip-flop |
| pv_valid | output | 1 | Parity flag override valid |
| pv_flag | output | 1 | Parity flag value (saved enable) |

## Verification
The enable flip-flops and the acknowledge outputs change at the clock edge that samples a strobe or boundary. The bench drives every stimulus on a falling edge and reads those results on the next falling edge. pv_flag is combinational, so it is read a step after the load-special strobe rises, inside the same cycle. Expected acknowledges are queued before each boundary is raised. A monitor takes them off the queue on the falling edge where ack must show, and any acknowledge with nothing queued is a failure. This checks both the one-cycle delay and the cases where nothing may be acknowledged.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] NMI_TARGET   = 16'h0066;
    localparam logic [ADDR_W-1:0] FIXED_TARGET = 16'h0038;

    typedef enum logic [1:0] {
        IM_BUS   = 2'd0,
        IM_FIXED = 2'd1,
        IM_TABLE = 2'd2
    } irq_mode_e;

    typedef struct packed {
        logic                 nmi;
        irq_mode_e            mode;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    data;
    } ack_info_t;

    function automatic logic [ADDR_W-1:0] table_addr(
        input logic [ADDR_W-DATA_W-1:0] page,
        input logic [DATA_W-1:0]        low
    );
        return {page, low[DATA_W-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/irq_enable_pair.sv
module irq_enable_pair (
    input  logic clk,
    input  logic rst,
    input  logic di_stb,
    input  logic ei_stb,
    input  logic retn_stb,
    input  logic take_nmi,
    input  logic take_int,
    output logic iff1,
    output logic iff2
);

    always_ff @(posedge clk) begin
        if (rst) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (take_nmi) begin
            iff1 <= 1'b0;
        end else if (take_int) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (di_stb) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (ei_stb) begin
            iff1 <= 1'b1;
            iff2 <= 1'b1;
        end else if (retn_stb) begin
            iff1 <= iff2;
        end
    end

    assert_disable_clears_R1: assert property (@(posedge clk) disable iff (rst)
        (di_stb && !take_nmi && !take_int) |=> (!iff1 && !iff2));

    assert_enable_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (ei_stb && !di_stb && !take_nmi && !take_int) |=> (iff1 && iff2));

    assert_nmi_keeps_saved_R3: assert property (@(posedge clk) disable iff (rst)
        take_nmi |=> (!iff1 && iff2 == $past(iff2)));

    assert_retn_restores_R4: assert property (@(posedge clk) disable iff (rst)
        (retn_stb && !ei_stb && !di_stb && !take_nmi && !take_int) |=> (iff1 == $past(iff2)));

endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic take,
    output logic pending
);

    logic nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q   <= 1'b0;
            pending <= 1'b0;
        end else begin
            nmi_q   <= nmi_in;
            pending <= (pending && !take) || (nmi_in && !nmi_q);
        end
    end

    assert_pending_needs_edge_R6: assert property (@(posedge clk) disable iff (rst)
        (!pending || take) |=> (!pending || $past(nmi_in)));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_ctl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] NMI_ADDR   = NMI_TARGET,
    parameter logic [ADDR_W-1:0] FIXED_ADDR = FIXED_TARGET
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     boundary,
    input  logic                     ei_stb,
    input  logic                     int_req,
    input  logic                     iff1,
    input  logic                     nmi_pend,
    input  irq_mode_e                mode,
    input  logic [ADDR_W-DATA_W-1:0] vec_page,
    input  logic [DATA_W-1:0]        bus_data,
    output logic                     take_nmi,
    output logic                     take_int,
    output logic                     ack,
    output ack_info_t                info
);

    logic ei_shadow;

    always_comb begin
        take_nmi = boundary && nmi_pend;
        take_int = boundary && !nmi_pend && int_req && iff1 && !ei_shadow;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ei_shadow <= 1'b0;
        end else if (ei_stb) begin
            ei_shadow <= 1'b1;
        end else if (boundary) begin
            ei_shadow <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack  <= 1'b0;
            info <= '{nmi: 1'b0, mode: IM_BUS, addr: '0, data: '0};
        end else if (take_nmi) begin
            ack       <= 1'b1;
            info.nmi  <= 1'b1;
            info.addr <= NMI_ADDR;
            info.data <= '0;
        end else if (take_int) begin
            ack       <= 1'b1;
            info.nmi  <= 1'b0;
            info.mode <= mode;
            info.data <= bus_data;
            case (mode)
                IM_FIXED: info.addr <= FIXED_ADDR;
                IM_TABLE: info.addr <= table_addr(vec_page, bus_data);
                default:  info.addr <= '0;
            endcase
        end else begin
            ack <= 1'b0;
        end
    end

    assert_maskable_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        (ack && !info.nmi) |-> $past(iff1));

    assert_ei_shadow_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(ei_stb) && boundary) |=> !(ack && !info.nmi));

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
    import irq_ctl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] NMI_ADDR   = NMI_TARGET,
    parameter logic [ADDR_W-1:0] FIXED_ADDR = FIXED_TARGET
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     di_stb,
    input  logic                     ei_stb,
    input  logic                     retn_stb,
    input  logic                     ldsp_stb,
    input  logic                     mode_wr,
    input  logic [1:0]               mode_sel,
    input  logic                     boundary,
    input  logic                     int_req,
    input  logic                     nmi_in,
    input  logic [DATA_W-1:0]        bus_data,
    input  logic [ADDR_W-DATA_W-1:0] vec_page,
    output logic                     ack,
    output logic                     ack_nmi,
    output logic [1:0]               ack_mode,
    output logic [ADDR_W-1:0]        rst_addr,
    output logic [DATA_W-1:0]        ack_opcode,
    output logic                     iff1,
    output logic                     iff2,
    output logic                     pv_valid,
    output logic                     pv_flag
);

    irq_mode_e mode_q;
    logic      nmi_pend;
    logic      take_nmi;
    logic      take_int;
    ack_info_t info;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= IM_BUS;
        end else if (mode_wr && mode_sel != 2'd3) begin
            mode_q <= irq_mode_e'(mode_sel);
        end
    end

    irq_nmi_edge u_nmi (
        .clk     (clk),
        .rst     (rst),
        .nmi_in  (nmi_in),
        .take    (take_nmi),
        .pending (nmi_pend)
    );

    irq_arbiter #(
        .NMI_ADDR   (NMI_ADDR),
        .FIXED_ADDR (FIXED_ADDR)
    ) u_arb (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .ei_stb   (ei_stb),
        .int_req  (int_req),
        .iff1     (iff1),
        .nmi_pend (nmi_pend),
        .mode     (mode_q),
        .vec_page (vec_page),
        .bus_data (bus_data),
        .take_nmi (take_nmi),
        .take_int (take_int),
        .ack      (ack),
        .info     (info)
    );

    irq_enable_pair u_iff (
        .clk      (clk),
        .rst      (rst),
        .di_stb   (di_stb),
        .ei_stb   (ei_stb),
        .retn_stb (retn_stb),
        .take_nmi (take_nmi),
        .take_int (take_int),
        .iff1     (iff1),
        .iff2     (iff2)
    );

    always_comb begin
        ack_nmi    = info.nmi;
        ack_mode   = info.mode;
        rst_addr   = info.addr;
        ack_opcode = info.data;
        pv_valid   = ldsp_stb;
        pv_flag    = ldsp_stb && iff2;
    end

    assert_ack_after_boundary_R14: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(boundary));

    assert_nmi_target_R3: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_nmi) |-> (rst_addr == NMI_ADDR));

endmodule

// File: tb/irq_accept_ctrl_test.sv
module irq_accept_ctrl_test;

    localparam int PERIOD = 10;

    typedef struct {
        logic        nmi;
        logic [1:0]  mode;
        logic [15:0] addr;
        logic [7:0]  data;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic di_stb = 0, ei_stb = 0, retn_stb = 0, ldsp_stb = 0;
    logic mode_wr = 0;
    logic [1:0] mode_sel = 0;
    logic boundary = 0, int_req = 0, nmi_in = 0;
    logic [7:0] bus_data = 0, vec_page = 0;
    logic ack, ack_nmi, iff1, iff2, pv_valid, pv_flag;
    logic [1:0] ack_mode;
    logic [15:0] rst_addr;
    logic [7:0] ack_opcode;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    always #(PERIOD/2) clk = ~clk;

    irq_accept_ctrl uut (
        .clk(clk), .rst(rst), .di_stb(di_stb), .ei_stb(ei_stb),
        .retn_stb(retn_stb), .ldsp_stb(ldsp_stb), .mode_wr(mode_wr),
        .mode_sel(mode_sel), .boundary(boundary), .int_req(int_req),
        .nmi_in(nmi_in), .bus_data(bus_data), .vec_page(vec_page),
        .ack(ack), .ack_nmi(ack_nmi), .ack_mode(ack_mode),
        .rst_addr(rst_addr), .ack_opcode(ack_opcode), .iff1(iff1),
        .iff2(iff2), .pv_valid(pv_valid), .pv_flag(pv_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on the falling edge where ack is due.
    always @(negedge clk) begin
        if (!rst && ack === 1'b1) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R14 unexpected ack actual addr=%h nmi=%b expected no ack", rst_addr, ack_nmi);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (ack_nmi !== e.nmi || rst_addr !== e.addr ||
                    (!e.nmi && (ack_mode !== e.mode || ack_opcode !== e.data))) begin
                    errors++;
                    $display("FAIL %s actual nmi=%b mode=%0d addr=%h data=%h expected nmi=%b mode=%0d addr=%h data=%h",
                             e.req, ack_nmi, ack_mode, rst_addr, ack_opcode,
                             e.nmi, e.mode, e.addr, e.data);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_ei();
        ei_stb = 1; tick(); ei_stb = 0;
    endtask
    task automatic do_di();
        di_stb = 1; tick(); di_stb = 0;
    endtask
    task automatic do_retn();
        retn_stb = 1; tick(); retn_stb = 0;
    endtask
    task automatic do_bnd();
        boundary = 1; tick(); boundary = 0;
    endtask
    task automatic expect_bnd(input logic nmi, input logic [1:0] mode,
                              input logic [15:0] addr, input logic [7:0] data, input string req);
        exp_t e;
        e.nmi = nmi; e.mode = mode; e.addr = addr; e.data = data; e.req = req;
        q.push_back(e);
        do_bnd();
    endtask
    task automatic set_mode(input logic [1:0] m);
        mode_wr = 1; mode_sel = m; tick(); mode_wr = 0;
    endtask
    task automatic check_pv(input logic exp, input string req);
        ldsp_stb = 1; #1;
        check({req, " pv_valid"}, pv_valid, 1);
        check({req, " pv_flag"}, pv_flag, exp);
        tick(); ldsp_stb = 0;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 0;
        // R1 reset state
        check("R1 reset iff1", iff1, 0);
        check("R1 reset iff2", iff2, 0);
        check("R14 reset ack", ack, 0);
        check("R1 reset addr", rst_addr, 0);

        // R8 disabled: request ignored
        int_req = 1; bus_data = 8'hFF;
        do_bnd();
        check("R8 no accept iff1", iff1, 0);

        // R2, R9, R11
        do_ei();
        check("R2 iff1", iff1, 1);
        check("R2 iff2", iff2, 1);
        do_bnd();                                  // shadow boundary: no ack (R9)
        expect_bnd(0, 2'd0, 16'h0000, 8'hFF, "R11 mode0");
        check("R8 cleared iff1", iff1, 0);
        check("R8 cleared iff2", iff2, 0);
        int_req = 0;

        // R12 mode 1
        set_mode(2'd1);
        do_ei(); do_bnd();
        int_req = 1;
        expect_bnd(0, 2'd1, 16'h0038, 8'hFF, "R12 mode1");
        int_req = 0;

        // R10 write of 3 ignored
        set_mode(2'd3);
        do_ei(); do_bnd();
        int_req = 1;
        expect_bnd(0, 2'd1, 16'h0038, 8'hFF, "R10 mode3 ignored");
        int_req = 0;

        // R13 mode 2
        set_mode(2'd2);
        vec_page = 8'h12; bus_data = 8'h35;
        do_ei(); do_bnd();
        int_req = 1;
        expect_bnd(0, 2'd2, 16'h1234, 8'h35, "R13 mode2");
        int_req = 0;

        // R3, R6 NMI with enables set, held high
        do_ei(); do_bnd();
        check("R2 iff1 before nmi", iff1, 1);
        nmi_in = 1;
        tick(); tick(); tick();
        expect_bnd(1, 2'd0, 16'h0066, 8'h00, "R6 pending held / R3 nmi");
        check("R3 iff1 cleared", iff1, 0);
        check("R3 iff2 kept", iff2, 1);
        do_bnd();                                  // level still high: no ack (R6)
        check_pv(1, "R5 saved=1");
        do_retn();
        check("R4 restore iff1", iff1, 1);
        nmi_in = 0; tick();

        // R7 priority
        int_req = 1; nmi_in = 1; tick();
        expect_bnd(1, 2'd0, 16'h0066, 8'h00, "R7 nmi wins");
        do_bnd();                                  // iff1=0: maskable not taken
        int_req = 0; nmi_in = 0;
        do_retn();
        check("R4 restore after R7", iff1, 1);

        // R1 disable, R5 with 0, R3 with enables clear, R4
        do_di();
        check("R1 di iff1", iff1, 0);
        check("R1 di iff2", iff2, 0);
        check_pv(0, "R5 saved=0");
        nmi_in = 1; tick();
        expect_bnd(1, 2'd0, 16'h0066, 8'h00, "R3 nmi while disabled");
        check("R3 iff2 stays 0", iff2, 0);
        do_retn();
        check("R4 restore 0", iff1, 0);
        nmi_in = 0;

        // R14 no sampling without boundary
        do_ei(); do_bnd();
        int_req = 1;
        tick(); tick(); tick();
        check("R14 no ack without boundary", ack, 0);
        expect_bnd(0, 2'd2, 16'h1234, 8'h35, "R14 accept at boundary");
        int_req = 0;
        tick();
        check("R14 ack width", ack, 0);
        tick(); tick();

        check("R14 queue drained", q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule